// File: doc/BRIEF.md
# Width-Halving Memory Bridge

This block lets a 32-bit processor datapath use a memory whose data port is only 16 bits wide. It runs on a clock at twice the processor rate. Each processor request, read or write, is split into two 16-bit memory beats. The low beat falls in the first half of the processor cycle and the high beat in the second half. The whole 32-bit access therefore completes inside one processor cycle, and the processor never waits.

The processor holds `req`, `we`, `addr` and `wdata` stable for one full processor cycle. That cycle is two fast cycles, starting where `beat_hi` is low. The memory side is driven combinationally from those inputs and from the internal phase flag. The memory returns read data in the same fast cycle in which it sees the address, and it writes on the fast rising edge. On a read, the low half-word is captured at the end of the first beat. It is joined with the high half-word at the end of the second beat. The joined word appears on `rdata` at the start of the following processor cycle and holds until the next read completes.

Top module: `halfword_mem_bridge`

## Requirements
- R1: While `rst_n` is low and directly after its release, `rdata` is all zeros and `beat_hi` is 0, so the first fast cycle after reset is a low beat.
- R2: In a fast cycle where `req` is 0, `mem_en` and `mem_we` are both 0.
- R3: With `req` high, `mem_en` is 1 in both beats. `mem_addr` is `{addr, 1'b0}` in the low beat (`beat_hi`=0) and `{addr, 1'b1}` in the high beat (`beat_hi`=1).
- R4: For a write (`req`=1, `we`=1), `mem_we` is 1 in both beats. The low beat drives `wdata[15:0]` on `mem_wdata` and the high beat drives `wdata[31:16]`. After the processor cycle, memory holds the low half at the even half-word address and the high half at the odd one.
- R5: For a read (`req`=1, `we`=0), `rdata` becomes `{word at odd address, word at even address}` on the fast edge that ends the high beat. It then holds that value through the whole next processor cycle.
- R6: Write cycles and idle cycles leave `rdata` unchanged. It keeps the value of the most recent read.
- R7: `beat_hi` alternates on every fast clock edge after reset.
- R8: Requests in consecutive processor cycles, in any mix of reads and writes, are each served completely in their own cycle, without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the processor rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Processor access request, held for a processor cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | WADDR_W | 32-bit word address |
| wdata | input | PROC_W | Write data from the processor |
| rdata | output | PROC_W | Assembled read data |
| beat_hi | output | 1 | 0 in the low (first) beat, 1 in the high (second) beat |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | WADDR_W+1 | Half-word address to memory |
| mem_wdata | output | MEM_W | Half-word write data to memory |
| mem_rdata | input | MEM_W | Half-word read data from memory |

## Verification
The bench builds the bridge with `WADDR_W` = 8 and the default data widths of 32 and 16. This keeps its half-word memory model at 512 entries. Random addresses then hit both the lowest and the highest word, and reads of addresses written earlier in the run become frequent. Since the whole space is small, the random mix of reads, writes and idle cycles often gives back-to-back accesses to the same word. It also exposes the ordering of the two half-words, because the top address bit and the beat bit both reach the memory.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
    // Which half of the processor cycle the bridge is serving.
    typedef enum logic {
        BEAT_LO = 1'b0,
        BEAT_HI = 1'b1
    } beat_e;
endpackage

// File: rtl/hwb_phase.sv
module hwb_phase
    import hwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output beat_e beat
);
    typedef struct packed {
        beat_e beat;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.beat = (st_q.beat == BEAT_LO) ? BEAT_HI : BEAT_LO;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.beat <= BEAT_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat = st_q.beat;

    // R7: the phase alternates on every fast edge.
    p_phase_alternates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.beat != $past(st_q.beat)));
endmodule

// File: rtl/hwb_beat_mux.sv
module hwb_beat_mux
    import hwb_pkg::*;
#(
    parameter int PROC_W  = 32,
    parameter int MEM_W   = 16,
    parameter int WADDR_W = 15,
    localparam int MADDR_W = WADDR_W + 1
) (
    input  logic               req,
    input  logic               we,
    input  logic [WADDR_W-1:0] addr,
    input  logic [PROC_W-1:0]  wdata,
    input  beat_e              beat,
    output logic               mem_en,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [MEM_W-1:0]   mem_wdata
);
    localparam int HALVES = PROC_W / MEM_W;

    logic [MEM_W-1:0] half_sel [HALVES];

    // Split the processor word into half-words, lowest first.
    for (genvar g = 0; g < HALVES; g++) begin : g_split
        assign half_sel[g] = wdata[g*MEM_W +: MEM_W];
    end

    always_comb begin
        mem_en    = req;
        mem_we    = req && we;
        mem_addr  = {addr, (beat == BEAT_HI)};
        mem_wdata = (beat == BEAT_HI) ? half_sel[HALVES-1] : half_sel[0];
        if (!req) begin
            mem_addr  = '0;
            mem_wdata = '0;
        end
    end
endmodule

// File: rtl/hwb_read_join.sv
module hwb_read_join
    import hwb_pkg::*;
#(
    parameter int PROC_W = 32,
    parameter int MEM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  beat_e             beat,
    input  logic [MEM_W-1:0]  mem_rdata,
    output logic [PROC_W-1:0] rdata
);
    typedef struct packed {
        logic [MEM_W-1:0]  lo;
        logic [PROC_W-1:0] word;
    } join_t;

    join_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd && beat == BEAT_LO) begin
            st_d.lo = mem_rdata;
        end
        if (rd && beat == BEAT_HI) begin
            st_d.word = {mem_rdata, st_q.lo};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.word;

    // R6: without a completing read beat the word output holds.
    p_rdata_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && beat == BEAT_HI) |=> $stable(rdata));

    // R5: the high half of the result is the half-word seen in the high beat.
    p_high_half_join_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && beat == BEAT_HI) |=> (rdata[PROC_W-1 -: MEM_W] == $past(mem_rdata)));
endmodule

// File: rtl/halfword_mem_bridge.sv
module halfword_mem_bridge
    import hwb_pkg::*;
#(
    parameter int PROC_W  = 32,
    parameter int MEM_W   = 16,
    parameter int WADDR_W = 15,
    localparam int MADDR_W = WADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [WADDR_W-1:0] addr,
    input  logic [PROC_W-1:0]  wdata,
    output logic [PROC_W-1:0]  rdata,
    output logic               beat_hi,
    output logic               mem_en,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [MEM_W-1:0]   mem_wdata,
    input  logic [MEM_W-1:0]   mem_rdata
);
    beat_e beat;
    logic  rd;

    assign rd      = req && !we;
    assign beat_hi = (beat == BEAT_HI);

    hwb_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .beat  (beat)
    );

    hwb_beat_mux #(
        .PROC_W  (PROC_W),
        .MEM_W   (MEM_W),
        .WADDR_W (WADDR_W)
    ) u_mux (
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .beat      (beat),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    hwb_read_join #(
        .PROC_W (PROC_W),
        .MEM_W  (MEM_W)
    ) u_join (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (rd),
        .beat      (beat),
        .mem_rdata (mem_rdata),
        .rdata     (rdata)
    );

    // R2: an idle cycle drives no enable and no strobe.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (!mem_en && !mem_we));

    // R4: a write strobe only comes with an enabled access.
    p_strobe_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R3: the half-word select bit of the address follows the phase.
    p_addr_lsb_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr[0] == beat_hi));

    // R1: in reset the output word is cleared.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));
endmodule

// File: tb/sim_halfword_mem_bridge.sv
`timescale 1ns/1ps
module sim_halfword_mem_bridge;
    localparam int PROC_W  = 32;
    localparam int MEM_W   = 16;
    localparam int WADDR_W = 8;
    localparam int MADDR_W = WADDR_W + 1;
    localparam int WORDS   = 1 << WADDR_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req = 1'b0;
    logic               we = 1'b0;
    logic [WADDR_W-1:0] addr = '0;
    logic [PROC_W-1:0]  wdata = '0;
    logic [PROC_W-1:0]  rdata;
    logic               beat_hi;
    logic               mem_en, mem_we;
    logic [MADDR_W-1:0] mem_addr;
    logic [MEM_W-1:0]   mem_wdata;
    logic [MEM_W-1:0]   mem_rdata;

    logic [MEM_W-1:0]  mem [1 << MADDR_W];
    logic [PROC_W-1:0] shadow [WORDS];
    logic [PROC_W-1:0] last_read;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    halfword_mem_bridge #(
        .PROC_W  (PROC_W),
        .MEM_W   (MEM_W),
        .WADDR_W (WADDR_W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .beat_hi   (beat_hi),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Half-word memory: read in the same cycle, write on the rising edge.
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    end

    function automatic logic [MADDR_W-1:0] exp_addr(logic [WADDR_W-1:0] a, logic hi);
        return {a, hi};
    endfunction

    function automatic logic [MEM_W-1:0] exp_half(logic [PROC_W-1:0] d, logic hi);
        return hi ? d[PROC_W-1 -: MEM_W] : d[MEM_W-1:0];
    endfunction

    task automatic check(input logic ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Check the memory-side outputs in the current beat (called at a falling edge).
    task automatic check_beat(input logic hi);
        check(beat_hi == hi, "R7", "beat phase", 64'(beat_hi), 64'(hi));
        if (!req) begin
            check(!mem_en && !mem_we, "R2", "idle enables",
                  64'({mem_en, mem_we}), 64'd0);
        end else begin
            check(mem_en, "R3", "enable", 64'(mem_en), 64'd1);
            check(mem_addr == exp_addr(addr, hi), "R3", "half address",
                  64'(mem_addr), 64'(exp_addr(addr, hi)));
            check(mem_we == we, "R4", "write strobe", 64'(mem_we), 64'(we));
            if (we) begin
                check(mem_wdata == exp_half(wdata, hi), "R4", "half data",
                      64'(mem_wdata), 64'(exp_half(wdata, hi)));
            end
        end
    endtask

    // One processor cycle: caller is at the falling edge inside a low beat.
    task automatic proc_cycle(input logic r, input logic w,
                              input logic [WADDR_W-1:0] a, input logic [PROC_W-1:0] d);
        req = r; we = w; addr = a; wdata = d;
        #0.1;
        check_beat(1'b0);
        @(negedge clk);
        check_beat(1'b1);
        @(negedge clk);
        if (r && w) begin
            shadow[a] = d;
            check(mem[exp_addr(a, 1'b0)] == d[MEM_W-1:0], "R4", "stored low half",
                  64'(mem[exp_addr(a, 1'b0)]), 64'(d[MEM_W-1:0]));
            check(mem[exp_addr(a, 1'b1)] == d[PROC_W-1 -: MEM_W], "R4", "stored high half",
                  64'(mem[exp_addr(a, 1'b1)]), 64'(d[PROC_W-1 -: MEM_W]));
        end
        if (r && !w) begin
            last_read = shadow[a];
            check(rdata == last_read, "R5", "joined read word", 64'(rdata), 64'(last_read));
        end else begin
            check(rdata == last_read, "R6", "read word held", 64'(rdata), 64'(last_read));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < (1 << MADDR_W); i++) mem[i] = 16'(i * 16'h3a1 + 16'h5);
        for (int i = 0; i < WORDS; i++)
            shadow[i] = {mem[exp_addr(WADDR_W'(i), 1'b1)], mem[exp_addr(WADDR_W'(i), 1'b0)]};
        last_read = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(rdata == '0, "R1", "rdata in reset", 64'(rdata), 64'd0);
        check(beat_hi == 1'b0, "R1", "phase in reset", 64'(beat_hi), 64'd0);
        @(posedge clk);
        #0.5 rst_n = 1'b1;
        @(negedge clk);
        check(beat_hi == 1'b0, "R1", "first beat low", 64'(beat_hi), 64'd0);
        check(rdata == '0, "R1", "rdata after reset", 64'(rdata), 64'd0);

        // Directed corners
        proc_cycle(1'b0, 1'b0, '0, '0);                              // R2 idle
        proc_cycle(1'b1, 1'b1, '0, 32'hdead_beef);                   // R4 lowest word
        proc_cycle(1'b1, 1'b1, '1, 32'hffff_0000);                   // R4 highest word
        proc_cycle(1'b1, 1'b0, '0, '0);                              // R5
        proc_cycle(1'b1, 1'b0, '1, '0);                              // R5 R8 back-to-back
        proc_cycle(1'b1, 1'b1, WADDR_W'(8'h55), 32'h0000_ffff);      // R6 write keeps rdata
        proc_cycle(1'b0, 1'b1, WADDR_W'(8'h55), 32'h1234_5678);      // R2 idle with we set
        proc_cycle(1'b1, 1'b0, WADDR_W'(8'h55), '0);                 // R8 read after write
        proc_cycle(1'b1, 1'b1, WADDR_W'(8'h55), 32'h0f0f_a5a5);      // R8 write after read
        proc_cycle(1'b1, 1'b0, WADDR_W'(8'h55), '0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0] k;
            k = 3'($urandom);
            proc_cycle(k != 3'd0, k[0], WADDR_W'($urandom), $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule